// File: doc/BRIEF.md
# Security Register Program Engine

This block is the serial command path for one-time-programmable security storage. It sits behind an SPI slave interface in clock/data mode 0 and understands exactly one command: program security register. The command is one opcode byte, then a three-byte address sent MSB first, then any number of data bytes. The engine holds four 256-byte registers on chip. It collects the data bytes in a staging buffer while chip-select is low. After chip-select returns high it merges the staged bytes into the selected register by walking through every offset.

A write is accepted only when all of these hold: the write-enable latch is set, the target register is not locked, the address is well formed, and the frame ended on a byte boundary. A programmed byte can only clear bits, never set them. A small side port sets the write-enable latch and the lock bits, and reads any stored byte back through a registered read path.

The SPI pins are sampled through a short synchronizer into the system clock domain. The serial clock must therefore run well below the system clock.

Top module: `secreg_prog_engine`

## Requirements
- R1: After reset, `wel_q` is 0 and every bit of `lock_q` is 0. At power-up every stored byte reads FFh. A later reset clears `wel_q` and `lock_q` but leaves the stored bytes unchanged.
- R2: Bits on `spi_mosi` are captured on rising edges of `spi_sclk` while `spi_cs_n` is low, MSB first. Only a first byte of 42h starts a program. A frame with any other first byte changes neither the stored bytes nor `wel_q`.
- R3: Address bits 15..12 pick register 0 to 3 and address bits 7..0 give the starting byte offset. On the read port, `rd_addr[9:8]` is the register number and `rd_addr[7:0]` is the offset. `rd_data` shows that byte one clock after `rd_addr` is presented.
- R4: If `wel_q` is 0 when chip-select rises, a program frame writes nothing.
- R5: A one-cycle pulse on `wel_set` sets `wel_q`. Any frame whose first full byte was 42h clears `wel_q` when chip-select rises, whether or not the write is accepted.
- R6: A pulse on bit i of `lock_set` sets bit i of `lock_q`. Only a reset clears it. A program aimed at a locked register writes nothing.
- R7: Each programmed byte becomes the bitwise AND of its previous value and the data byte that was sent.
- R8: A frame may carry 1 to 256 or more data bytes. Successive bytes go to successive offsets, which wrap modulo 256 inside the same register. When more than one byte lands on the same offset, the last one sent is used.
- R9: A program frame that ends with a partial data byte, or that carries no data byte at all, writes nothing.
- R10: A program frame writes nothing if address bits 23..16 are nonzero, if address bits 11..8 are nonzero, or if bits 15..12 name a register number of 4 or higher.
- R11: While chip-select is still low, reads return the old contents. The new contents are readable no later than 300 clock cycles after chip-select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock, mode 0 |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data into the engine |
| wel_set | input | 1 | Pulse that sets the write-enable latch |
| lock_set | input | NREG | Per-register pulse that sets the lock bit |
| rd_addr | input | 10 | Read port address: register number, then offset |
| rd_data | output | 8 | Registered read data |
| wel_q | output | 1 | Write-enable latch |
| lock_q | output | NREG | Lock bits, one per register |

## Verification
The assertions assume that chip-select stays high until the merge walk of the previous frame is finished. They also assume that `wel_set` is never pulsed in the same cycle as the end of a program frame, and that serial clock edges are at least a few system clocks apart. The bench meets these conditions in three ways. It holds each serial clock level for three system clocks. It waits 300 clocks after every chip-select rise. It pulses the side-port inputs only while no frame is open. Reads are issued from the falling clock edge, so the read-stability property only ever sees a steady address during idle stretches.

// File: rtl/secreg_pkg.sv
`timescale 1ns/1ps
package secreg_pkg;
  localparam int OFF_W     = 8;
  localparam int REG_BYTES = 1 << OFF_W;
  localparam int BYTE_W    = 8;
  typedef enum logic [2:0] {PH_OP, PH_A2, PH_A1, PH_A0, PH_DATA} phase_e;
endpackage

// File: rtl/secreg_shifter.sv
`timescale 1ns/1ps
module secreg_shifter
  import secreg_pkg::*;
#(
  parameter int          NREG    = 4,
  parameter logic [7:0]  PROG_OP = 8'h42,
  localparam int         SEL_W   = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_i,
  input  logic              csn_i,
  input  logic              mosi_i,
  output logic              start_o,
  output logic              wr_en_o,
  output logic [OFF_W-1:0]  wr_off_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              end_o,
  output logic              attempt_o,
  output logic              ok_o,
  output logic [SEL_W-1:0]  sel_o
);
  localparam logic [OFF_W-1:0] OFF_ONE = 1;
  localparam logic [3:0]       NREG_F  = 4'(NREG);

  logic [1:0] sclk_q, csn_q;
  logic       mosi_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 2'b00;
      csn_q  <= 2'b11;
      mosi_q <= 1'b0;
    end else begin
      sclk_q <= {sclk_q[0], sclk_i};
      csn_q  <= {csn_q[0], csn_i};
      mosi_q <= mosi_i;
    end
  end

  logic sclk_rise, cs_fall, cs_rise, selected;
  assign sclk_rise = sclk_q[0] & ~sclk_q[1];
  assign cs_fall   = ~csn_q[0] & csn_q[1];
  assign cs_rise   = csn_q[0] & ~csn_q[1];
  assign selected  = ~csn_q[0];

  logic [6:0]       sh;
  logic [2:0]       bitcnt;
  phase_e           phase;
  logic [7:0]       opc;
  logic [15:0]      adr_hi;   // address bits 23..8
  logic [OFF_W-1:0] ptr;
  logic             got;
  logic [7:0]       byte_nxt;
  assign byte_nxt = {sh, mosi_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh <= '0; bitcnt <= '0; phase <= PH_OP; opc <= '0; adr_hi <= '0;
      ptr <= '0; got <= 1'b0; wr_en_o <= 1'b0; wr_off_o <= '0; wr_data_o <= '0;
      start_o <= 1'b0; end_o <= 1'b0; attempt_o <= 1'b0; ok_o <= 1'b0; sel_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      end_o   <= 1'b0;
      start_o <= cs_fall;
      if (cs_fall) begin
        bitcnt <= '0;
        phase  <= PH_OP;
        got    <= 1'b0;
        opc    <= '0;
      end else if (selected && sclk_rise) begin
        sh     <= byte_nxt[6:0];
        bitcnt <= bitcnt + 3'd1;
        if (bitcnt == 3'd7) begin
          case (phase)
            PH_OP:   begin opc <= byte_nxt;           phase <= PH_A2;   end
            PH_A2:   begin adr_hi[15:8] <= byte_nxt;  phase <= PH_A1;   end
            PH_A1:   begin adr_hi[7:0]  <= byte_nxt;  phase <= PH_A0;   end
            PH_A0:   begin ptr <= byte_nxt;           phase <= PH_DATA; end
            default: begin
              if (opc == PROG_OP) begin
                wr_en_o   <= 1'b1;
                wr_off_o  <= ptr;
                wr_data_o <= byte_nxt;
                got       <= 1'b1;
              end
              ptr <= ptr + OFF_ONE;
            end
          endcase
        end
      end
      if (cs_rise) begin
        end_o     <= 1'b1;
        attempt_o <= (phase != PH_OP) && (opc == PROG_OP);
        ok_o      <= (phase == PH_DATA) && got && (bitcnt == 3'd0) &&
                     (adr_hi[15:8] == 8'h00) && (adr_hi[3:0] == 4'h0) &&
                     (adr_hi[7:4] < NREG_F);
        sel_o     <= adr_hi[4 +: SEL_W];
      end
    end
  end
endmodule

// File: rtl/secreg_commit.sv
`timescale 1ns/1ps
module secreg_commit
  import secreg_pkg::*;
#(
  parameter int  NREG  = 4,
  localparam int SEL_W = $clog2(NREG),
  localparam int AW    = SEL_W + OFF_W,
  localparam int DEPTH = NREG * REG_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic [OFF_W-1:0]  wr_off_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              go_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              busy_o
);
  localparam logic [OFF_W-1:0] OFF_MAX = '1;
  localparam logic [OFF_W-1:0] OFF_ONE = 1;

  logic [BYTE_W-1:0]    store [DEPTH];
  logic [BYTE_W-1:0]    stage [REG_BYTES];
  logic [REG_BYTES-1:0] vmap;

  initial begin
    for (int i = 0; i < DEPTH; i++) store[i] = 8'hFF;
  end

  logic              walking, p_vld;
  logic [OFF_W-1:0]  idx;
  logic [SEL_W-1:0]  wsel;
  logic [AW-1:0]     p_adr;
  logic [BYTE_W-1:0] p_old, p_new;

  always_ff @(posedge clk) begin
    if (rst) begin
      walking <= 1'b0; idx <= '0; wsel <= '0; p_vld <= 1'b0; vmap <= '0;
    end else begin
      p_vld <= walking & vmap[idx];
      if (go_i) begin
        walking <= 1'b1;
        idx     <= '0;
        wsel    <= sel_i;
      end else if (walking) begin
        idx <= idx + OFF_ONE;
        if (idx == OFF_MAX) walking <= 1'b0;
      end
      if (clr_i) vmap <= '0;
      else if (wr_en_i) vmap[wr_off_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    p_adr     <= {wsel, idx};
    p_old     <= store[{wsel, idx}];
    p_new     <= stage[idx];
    rd_data_o <= store[rd_addr_i];
    if (wr_en_i) stage[wr_off_i] <= wr_data_i;
    if (p_vld) store[p_adr] <= p_old & p_new;
  end

  assign busy_o = walking | p_vld;
endmodule

// File: rtl/secreg_prog_engine.sv
`timescale 1ns/1ps
module secreg_prog_engine
  import secreg_pkg::*;
#(
  parameter int          NREG    = 4,
  parameter logic [7:0]  PROG_OP = 8'h42,
  localparam int         SEL_W   = $clog2(NREG),
  localparam int         AW      = SEL_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  input  logic              wel_set,
  input  logic [NREG-1:0]   lock_set,
  input  logic [AW-1:0]     rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic              wel_q,
  output logic [NREG-1:0]   lock_q
);
  logic              start_p, wr_en, end_p, attempt, cmd_ok, go, commit_busy;
  logic [OFF_W-1:0]  wr_off;
  logic [BYTE_W-1:0] wr_data;
  logic [SEL_W-1:0]  cmd_sel;

  secreg_shifter #(.NREG(NREG), .PROG_OP(PROG_OP)) u_shift (
    .clk(clk), .rst(rst), .sclk_i(spi_sclk), .csn_i(spi_cs_n), .mosi_i(spi_mosi),
    .start_o(start_p), .wr_en_o(wr_en), .wr_off_o(wr_off), .wr_data_o(wr_data),
    .end_o(end_p), .attempt_o(attempt), .ok_o(cmd_ok), .sel_o(cmd_sel)
  );

  assign go = end_p & cmd_ok & wel_q & ~lock_q[cmd_sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      wel_q  <= 1'b0;
      lock_q <= '0;
    end else begin
      if (end_p && attempt) wel_q <= 1'b0;
      else if (wel_set)     wel_q <= 1'b1;
      lock_q <= lock_q | lock_set;
    end
  end

  secreg_commit #(.NREG(NREG)) u_commit (
    .clk(clk), .rst(rst), .clr_i(start_p), .wr_en_i(wr_en), .wr_off_i(wr_off),
    .wr_data_i(wr_data), .go_i(go), .sel_i(cmd_sel), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .busy_o(commit_busy)
  );
endmodule

// File: rtl/secreg_prog_checker.sv
`timescale 1ns/1ps
module secreg_prog_checker #(
  parameter int  NREG  = 4,
  localparam int SEL_W = $clog2(NREG),
  localparam int AW    = SEL_W + 8
) (
  input logic            clk,
  input logic            rst,
  input logic            wel_set,
  input logic [AW-1:0]   rd_addr,
  input logic [7:0]      rd_data,
  input logic            wel_q,
  input logic [NREG-1:0] lock_q,
  input logic            end_p,
  input logic            attempt,
  input logic            busy,
  input logic [SEL_W-1:0] cmd_sel
);
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    (($past(lock_q) & ~lock_q) == '0)); // R6

  AST_WEL_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (end_p && attempt) |=> !wel_q); // R5

  AST_WEL_SETS: assert property (@(posedge clk) disable iff (rst)
    (wel_set && !(end_p && attempt)) |=> wel_q); // R5

  AST_MERGE_GATED: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(wel_q) && !$past(lock_q[cmd_sel]))); // R4

  AST_IDLE_READ_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(busy, 1) && !$past(busy, 2) && ($past(rd_addr, 1) == $past(rd_addr, 2)))
      |-> $stable(rd_data)); // R11
endmodule

bind secreg_prog_engine secreg_prog_checker #(.NREG(NREG)) u_chk (
  .clk(clk), .rst(rst), .wel_set(wel_set), .rd_addr(rd_addr), .rd_data(rd_data),
  .wel_q(wel_q), .lock_q(lock_q), .end_p(end_p), .attempt(attempt),
  .busy(commit_busy), .cmd_sel(cmd_sel)
);

// File: tb/secreg_prog_engine_test.sv
`timescale 1ns/1ps
module secreg_prog_engine_test;
  localparam int NREG = 4;
  localparam int TOT  = NREG * 256;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rst = 1'b1;
  logic            spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic            wel_set = 1'b0;
  logic [NREG-1:0] lock_set = '0;
  logic [9:0]      rd_addr = '0;
  logic [7:0]      rd_data;
  logic            wel_q;
  logic [NREG-1:0] lock_q;

  secreg_prog_engine uut (
    .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .wel_set(wel_set), .lock_set(lock_set), .rd_addr(rd_addr), .rd_data(rd_data),
    .wel_q(wel_q), .lock_q(lock_q)
  );

  int vecs = 0, errs = 0;
  bit done = 0;
  logic [7:0]      model [TOT];
  bit              m_wel = 0;
  logic [NREG-1:0] m_lock = '0;

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp, string what);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] dat(int seed, int k);
    return 8'((seed * 29 + k * 53) ^ (k >> 1));
  endfunction

  task automatic spi_bit(logic b);
    spi_mosi = b; tick(3); spi_sclk = 1'b1; tick(3); spi_sclk = 1'b0;
  endtask

  task automatic spi_byte(logic [7:0] v);
    for (int i = 7; i >= 0; i--) spi_bit(v[i]);
  endtask

  task automatic send_body(logic [7:0] op, logic [23:0] adr, int n, int seed, int extra);
    spi_cs_n = 1'b0; tick(4);
    spi_byte(op);
    spi_byte(adr[23:16]); spi_byte(adr[15:8]); spi_byte(adr[7:0]);
    for (int k = 0; k < n; k++) spi_byte(dat(seed, k));
    for (int e = 0; e < extra; e++) spi_bit(1'b0);
  endtask

  task automatic finish_cmd();
    tick(3); spi_cs_n = 1'b1; tick(300);
  endtask

  task automatic model_apply(logic [7:0] op, logic [23:0] adr, int n, int seed, int extra);
    logic [7:0] st [256];
    bit         v  [256];
    int         sel;
    bit         acc;
    if (op != 8'h42) return;
    sel = int'(adr[15:12]);
    acc = m_wel && adr[23:16] == 8'h00 && adr[11:8] == 4'h0 && sel < NREG &&
          n >= 1 && extra == 0;
    if (acc) acc = !m_lock[sel];
    m_wel = 0;
    if (!acc) return;
    for (int o = 0; o < 256; o++) v[o] = 0;
    for (int k = 0; k < n; k++) begin
      st[(int'(adr[7:0]) + k) % 256] = dat(seed, k);
      v[(int'(adr[7:0]) + k) % 256]  = 1;
    end
    for (int o = 0; o < 256; o++)
      if (v[o]) model[sel * 256 + o] = model[sel * 256 + o] & st[o];
  endtask

  task automatic prog(logic [7:0] op, logic [23:0] adr, int n, int seed, int extra);
    send_body(op, adr, n, seed, extra);
    finish_cmd();
    model_apply(op, adr, n, seed, extra);
  endtask

  task automatic read_at(int a, output logic [7:0] v);
    rd_addr = 10'(a); tick(1); v = rd_data;
  endtask

  task automatic check_all(string tag);
    logic [7:0] v;
    for (int a = 0; a < TOT; a++) begin
      read_at(a, v);
      chk(tag, int'(v), int'(model[a]), $sformatf("byte %0d", a));
    end
  endtask

  task automatic pulse_wel();
    wel_set = 1'b1; tick(1); wel_set = 1'b0; m_wel = 1; tick(1);
  endtask

  task automatic pulse_lock(logic [NREG-1:0] m);
    lock_set = m; tick(1); lock_set = '0; m_lock = m_lock | m; tick(1);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    for (int a = 0; a < TOT; a++) model[a] = 8'hFF;
    tick(5); rst = 1'b0; tick(2);

    // R1: reset state and erased store
    chk("R1", int'(wel_q), 0, "wel after reset");
    chk("R1", int'(lock_q), 0, "locks after reset");
    check_all("R1");

    // R4: program without write enable
    prog(8'h42, 24'h001010, 4, 1, 0);
    chk("R4", int'(wel_q), 0, "wel stays low");
    check_all("R4");

    // R5: set latch; R2: foreign opcodes leave store and latch alone
    pulse_wel();
    chk("R5", int'(wel_q), 1, "wel after set pulse");
    prog(8'h02, 24'h001000, 3, 2, 0);
    prog(8'h43, 24'h001000, 3, 3, 0);
    chk("R2", int'(wel_q), 1, "wel kept by other opcode");
    check_all("R2");

    // R3/R8: register 1, offset F0, 20 bytes crossing the wrap
    prog(8'h42, 24'h0010F0, 20, 4, 0);
    chk("R5", int'(wel_q), 0, "wel cleared after accepted program");
    check_all("R3");

    // R7: overlapping reprogram merges by AND
    pulse_wel();
    prog(8'h42, 24'h0010F8, 10, 9, 0);
    check_all("R7");

    // R9: trailing partial byte, then no data at all
    pulse_wel();
    prog(8'h42, 24'h002020, 2, 5, 3);
    chk("R9", int'(wel_q), 0, "wel cleared after partial frame");
    pulse_wel();
    prog(8'h42, 24'h002020, 0, 5, 0);
    chk("R9", int'(wel_q), 0, "wel cleared after empty frame");
    check_all("R9");

    // R10: malformed addresses
    pulse_wel(); prog(8'h42, 24'h102000, 2, 6, 0);
    pulse_wel(); prog(8'h42, 24'h002100, 2, 6, 0);
    pulse_wel(); prog(8'h42, 24'h004000, 2, 6, 0);
    chk("R10", int'(wel_q), 0, "wel cleared after bad address");
    check_all("R10");

    // R6: lock register 3, sticky, program ignored; register 0 still works
    pulse_lock(4'b1000);
    pulse_lock(4'b0000);
    chk("R6", int'(lock_q), 8, "lock bits");
    pulse_wel(); prog(8'h42, 24'h003000, 8, 7, 0);
    pulse_wel(); prog(8'h42, 24'h000000, 8, 8, 0);
    chk("R6", int'(lock_q), 8, "lock bits still set");
    check_all("R6");

    // R8: 300 bytes into register 2 from offset 80, last write per offset wins
    pulse_wel();
    prog(8'h42, 24'h002080, 300, 11, 0);
    check_all("R8");

    // R11: no change visible before chip-select rises
    pulse_wel();
    send_body(8'h42, 24'h000005, 1, 12, 0);
    tick(20);
    read_at(5, v);
    chk("R11", int'(v), int'(model[5]), "byte before chip-select rise");
    finish_cmd();
    model_apply(8'h42, 24'h000005, 1, 12, 0);
    read_at(5, v);
    chk("R11", int'(v), int'(model[5]), "byte after merge window");

    // R1: later reset clears latch and locks, keeps contents
    pulse_wel();
    rst = 1'b1; tick(3); rst = 1'b0; tick(2);
    m_wel = 0; m_lock = '0;
    chk("R1", int'(wel_q), 0, "wel after second reset");
    chk("R1", int'(lock_q), 0, "locks after second reset");
    check_all("R1");

    done = 1;
    summary();
    $finish;
  end
endmodule